// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives clause-22 management frames onto a two-wire PHY management bus (a clock line and a bidirectional data line). Software writes one packed 32-bit command word. That single write starts one read or one write transaction. The block sends 32 preamble ones and then the 32 command bits, most significant bit first. For a read, it releases the data line for the turnaround and data bits, so the PHY can drive it. It then captures the 16 returned bits into the low half of the command register.

When any frame ends, the block sets a completion event, and the interrupt line follows that event. A speed register sets the management clock divider. A control register offers a self-clearing soft reset and shows a busy flag. The register port is a plain synchronous port with no back-pressure: a write takes effect on the clock edge where `reg_we` is high, and `reg_rdata` reflects `reg_addr` combinationally. The PHY pins have no handshake. The bus timing is fully set by the divider.

Top module: `mdio_frame_master`

## Requirements
- R1: Writing word address 0 while idle starts exactly one frame: 32 ones, then command bits 31 down to 0. The command layout is start 31:30 = 01, opcode 29:28 (10 read, 01 write), PHY address 27:23, register 22:18, turnaround 17:16 = 10, data 15:0. Address 0 reads back the stored command.
- R2: With divider d > 0, `mdc` idles low and has a period of 2·d clock cycles. `mdio_o` changes only on a falling edge of `mdc` (or at frame start). The PHY data is sampled on the rising edge.
- R3: With divider 0, `mdc` stays low and a started frame does not advance.
- R4: During a read (opcode 10), `mdio_oe` is high for frame bit positions 0..45 and low from position 46 (the turnaround) to 63. During a write it is high for all 64 positions. While idle it is low.
- R5: When a read ends, the 16 sampled bits replace command bits 15:0, and bits 31:16 are kept.
- R6: A read with nobody driving the line (line held at 1) returns 0xFFFF.
- R7: The end of any frame sets the event bit (address 1, bit 0), and `irq` equals that bit. Writing 1 to bit 0 clears it, writing 0 leaves it set, and writing all ones clears it.
- R8: The control register (address 2) shows busy on bit 1. A command written while busy is ignored: it neither changes the frame on the bus nor the stored command.
- R9: Writing 1 to control bit 0 starts a soft reset. Bit 0 reads 1 for RST_CYCLES cycles and then clears itself. The soft reset aborts any frame, clears the event, stops `mdc` low and releases `mdio_oe`.
- R10: The speed register (address 3) holds the divider in bits 6:1 and reads back the same. After reset, all registers read 0, `mdc` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the line |
| mdio_o | output | 1 | Management data to the line |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| irq | output | 1 | Completion event pending |

## Verification
The bench chooses random dividers and random read and write commands. It records the line at every rising edge of `mdc` and compares all 64 bit positions and the drive enable against a frame it builds from the command word. A wrong turnaround boundary, a lost preamble bit or a misordered field would show up as a specific position mismatch. A PHY model drives random data, or no data at all, which exposes a design that shifts in the wrong direction or samples on the wrong edge. The directed cases cover a second command written mid-frame (a design that accepts it would corrupt the bus), a zero divider (a design that does not stall would still toggle `mdc`), writing 0 versus all ones to the event bit, and a soft reset that must abort a stalled frame and then clear itself.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 2;
  localparam int REG_W    = 32;
  localparam int DIV_W    = 6;
  localparam int PRE_W    = 32;
  localparam int DATA_W   = 16;

  localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_EVT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] A_SPD  = 2'd3;

  localparam logic [1:0] OP_RD = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && (div != '0) && (cnt == div - 1'b1);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (div != '0) begin
      if (tick) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: a zero divider freezes the management clock
  a_r3_mdc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div == '0) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [REG_W-1:0]  cmd,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              is_rd,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int TOT    = PRE_W + REG_W;
  localparam int CNT_W  = $clog2(TOT);
  localparam int FI_W   = $clog2(REG_W);
  localparam int TA_IDX = TOT - DATA_W - 2;
  localparam int DT_IDX = TOT - DATA_W;

  logic [REG_W-1:0]  frame;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  fidx;
  logic [DATA_W-1:0] cap;

  assign fidx    = CNT_W'(TOT - 1) - bit_cnt;
  assign done    = busy && fall && (bit_cnt == CNT_W'(TOT - 1));
  assign rd_data = cap;

  always_comb begin
    if (!busy || bit_cnt < CNT_W'(PRE_W)) mdio_o = 1'b1;
    else                                   mdio_o = frame[fidx[FI_W-1:0]];
  end

  always_comb begin
    mdio_oe = busy;
    if (busy && is_rd && bit_cnt >= CNT_W'(TA_IDX)) mdio_oe = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      frame   <= '0;
      bit_cnt <= '0;
      cap     <= '0;
    end else if (clr) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        frame   <= cmd;
        is_rd   <= (cmd[REG_W-3 -: 2] == OP_RD);
        bit_cnt <= '0;
        cap     <= '0;
      end
    end else begin
      if (rise && is_rd && bit_cnt >= CNT_W'(DT_IDX))
        cap <= {cap[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (bit_cnt == CNT_W'(TOT - 1)) busy <= 1'b0;
        else                            bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R2: line data only moves after a falling clock edge
  a_r2_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall) && !$past(clr)) |-> $stable(mdio_o));
  // R4: nothing is driven while idle
  a_r4_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              irq
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [REG_W-1:0]  cmd_q;
  logic              evt_q;
  logic [DIV_W-1:0]  div_q;
  logic [RC_W-1:0]   rst_cnt;
  logic              srst, busy, is_rd, done, rise, fall, start;
  logic [DATA_W-1:0] rd_data;
  logic              wr_cmd, wr_evt, wr_ctrl, wr_spd;

  assign srst    = (rst_cnt != '0);
  assign wr_cmd  = reg_we && reg_addr == A_CMD;
  assign wr_evt  = reg_we && reg_addr == A_EVT;
  assign wr_ctrl = reg_we && reg_addr == A_CTRL;
  assign wr_spd  = reg_we && reg_addr == A_SPD;
  assign start   = wr_cmd && !busy && !srst;
  assign irq     = evt_q;

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy && !srst), .div(div_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .clr(srst), .start(start), .cmd(reg_wdata),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(busy), .is_rd(is_rd),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      evt_q   <= 1'b0;
      div_q   <= '0;
      rst_cnt <= '0;
    end else begin
      if (start)
        cmd_q <= reg_wdata;
      else if (done && is_rd)
        cmd_q[DATA_W-1:0] <= rd_data;

      if (wr_spd) div_q <= reg_wdata[DIV_W:1];

      if (wr_ctrl && reg_wdata[0]) rst_cnt <= RC_W'(RST_CYCLES);
      else if (srst)               rst_cnt <= rst_cnt - 1'b1;

      if (srst || (wr_ctrl && reg_wdata[0])) evt_q <= 1'b0;
      else if (done)                          evt_q <= 1'b1;
      else if (wr_evt && reg_wdata[0])        evt_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CMD:   reg_rdata = cmd_q;
      A_EVT:   reg_rdata = {{(REG_W-1){1'b0}}, evt_q};
      A_CTRL:  reg_rdata = {{(REG_W-2){1'b0}}, busy, srst};
      default: reg_rdata = {{(REG_W-DIV_W-1){1'b0}}, div_q, 1'b0};
    endcase
  end

  // R8: a command written mid-frame leaves the stored word alone
  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd && !done) |=> $stable(cmd_q));
  // R7: frame completion raises the event
  a_r7_done_sets_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_ctrl) |=> evt_q);
  // R9: soft reset leaves the bus idle
  a_r9_srst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!mdio_oe && !mdc));
endmodule

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;
  localparam int CLK_P = 10;
  localparam int RSTC  = 8;

  logic        clk = 0, rst_n = 0, reg_we = 0, mdio_i = 1;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  logic [63:0] seen_o, seen_oe;
  int          rise_idx = 0;
  time         last_rise;
  int          exp_period = 0, per_bad = 0;
  bit          phy_on = 0;
  logic [15:0] phy_data = 0;

  always #(CLK_P/2) clk = ~clk;

  mdio_frame_master #(.RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq(irq)
  );

  always @(posedge mdc) begin
    if (rise_idx < 64) begin
      seen_o[rise_idx]  = mdio_o;
      seen_oe[rise_idx] = mdio_oe;
    end
    if (rise_idx > 0 && ($time - last_rise) != exp_period * CLK_P) per_bad++;
    last_rise = $time;
    rise_idx++;
  end

  always @(negedge mdc)
    mdio_i = (phy_on && rise_idx >= 48 && rise_idx <= 63) ? phy_data[63 - rise_idx] : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_cmd(input bit is_read, input logic [4:0] pa,
                                         input logic [4:0] ra, input logic [15:0] dat);
    return {2'b01, is_read ? 2'b10 : 2'b01, pa, ra, 2'b10, is_read ? 16'h0000 : dat};
  endfunction

  task automatic wait_irq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
  endtask

  task automatic run_frame(input logic [31:0] cmd, input int d, input bit pon,
                           input logic [15:0] pdat);
    logic [31:0] r;
    int bad_o = 0, bad_oe = 0;
    bit is_read = (cmd[29:28] == 2'b10);
    wr(2'd3, {25'b0, 6'(d), 1'b0});
    phy_on = pon; phy_data = pdat; exp_period = 2 * d; per_bad = 0; rise_idx = 0;
    wr(2'd0, cmd);
    wait_irq();
    chk(irq == 1'b1, "R7 irq after frame", {31'b0, irq}, 32'd1);
    for (int k = 0; k < 64; k++) begin
      logic eb = (k < 32) ? 1'b1 : cmd[63 - k];
      logic eo = (!is_read || k < 46);
      if ((!is_read || k < 46) && seen_o[k] !== eb) bad_o++;
      if (seen_oe[k] !== eo) bad_oe++;
    end
    chk(rise_idx == 64, "R1 frame length", 32'(rise_idx), 32'd64);
    chk(bad_o == 0, "R1 frame bits", 32'(bad_o), 0);
    chk(bad_oe == 0, "R4 drive enable", 32'(bad_oe), 0);
    chk(per_bad == 0, "R2 mdc period", 32'(per_bad), 0);
    rd(2'd0, r);
    if (is_read) chk(r == {cmd[31:16], pon ? pdat : 16'hFFFF}, pon ? "R5 read data" : "R6 no phy",
                     r, {cmd[31:16], pon ? pdat : 16'hFFFF});
    else chk(r == cmd, "R1 command readback", r, cmd);
    chk(mdio_oe == 0 && mdc == 0, "R4 idle after frame", {30'b0, mdc, mdio_oe}, 0);
  endtask

  initial begin
    logic [31:0] r, c1;
    int cnt0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk(r == 0, "R10 reset value", r, 0);
    end
    chk(mdc == 0 && irq == 0 && mdio_oe == 0, "R10 reset pins", {29'b0, mdc, irq, mdio_oe}, 0);

    wr(2'd3, 32'h0000_0006);
    rd(2'd3, r);
    chk(r == 32'h6, "R10 speed readback", r, 32'h6);

    for (int n = 0; n < 6; n++) begin
      int d = 1 + ($urandom % 4);
      run_frame(mk_cmd(0, 5'($urandom), 5'($urandom), 16'($urandom)), d, 0, 0);
      wr(2'd1, 32'h1);
    end
    for (int n = 0; n < 6; n++) begin
      int d = 1 + ($urandom % 4);
      run_frame(mk_cmd(1, 5'($urandom), 5'($urandom), 0), d, 1, 16'($urandom));
      wr(2'd1, 32'h1);
    end
    run_frame(mk_cmd(1, 5'd31, 5'd2, 0), 2, 1, 16'h8001);
    wr(2'd1, 32'h1);
    run_frame(mk_cmd(1, 5'd0, 5'd3, 0), 3, 0, 0);

    // R7 event clear rules
    wr(2'd1, 32'h0);
    rd(2'd1, r);
    chk(r == 1, "R7 write 0 keeps event", r, 1);
    wr(2'd1, 32'h1);
    rd(2'd1, r);
    chk(r == 0 && irq == 0, "R7 write 1 clears", r, 0);
    run_frame(mk_cmd(0, 5'd1, 5'd0, 16'h1234), 1, 0, 0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r);
    chk(r == 0, "R7 all ones clears", r, 0);

    // R8 busy and ignored second command
    c1 = mk_cmd(0, 5'd5, 5'd9, 16'hA5C3);
    wr(2'd3, 32'h4);
    phy_on = 0; exp_period = 4; per_bad = 0; rise_idx = 0;
    wr(2'd0, c1);
    repeat (20) @(negedge clk);
    rd(2'd2, r);
    chk(r == 32'h2, "R8 busy flag", r, 32'h2);
    wr(2'd0, mk_cmd(1, 5'd7, 5'd7, 16'h0));
    rd(2'd0, r);
    chk(r == c1, "R8 stored command kept", r, c1);
    wait_irq();
    begin
      int bad = 0;
      for (int k = 0; k < 64; k++)
        if (seen_o[k] !== ((k < 32) ? 1'b1 : c1[63 - k]) || seen_oe[k] !== 1'b1) bad++;
      chk(bad == 0 && rise_idx == 64, "R8 frame unaffected", 32'(bad), 0);
    end

    // R3 zero divider stalls; event left pending on purpose
    wr(2'd3, 32'h0);
    rise_idx = 0;
    wr(2'd0, mk_cmd(0, 5'd2, 5'd2, 16'h0F0F));
    cnt0 = rise_idx;
    repeat (60) @(negedge clk);
    rd(2'd2, r);
    chk(rise_idx == cnt0 && mdc == 0, "R3 mdc stopped", 32'(rise_idx), 32'(cnt0));
    chk(r == 32'h2, "R3 frame held busy", r, 32'h2);

    // R9 soft reset
    wr(2'd2, 32'h1);
    rd(2'd2, r);
    chk(r[0] == 1'b1, "R9 reset bit set", r, 32'h1);
    chk(irq == 0, "R9 event cleared", {31'b0, irq}, 0);
    repeat (RSTC + 2) @(negedge clk);
    rd(2'd2, r);
    chk(r == 0, "R9 self clear and abort", r, 0);
    chk(mdio_oe == 0 && mdc == 0, "R9 bus idle", {30'b0, mdc, mdio_oe}, 0);
    run_frame(mk_cmd(1, 5'd4, 5'd1, 0), 2, 1, 16'h5A96);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule